// File: doc/BRIEF.md
# Indirect Memory Access Bridge

This block is a slave on a narrow byte-wide host bus. It gives the host access to a 64 KiB internal byte memory through four register offsets. The host loads a 16-bit pointer through a pair of address registers. It then moves bytes one at a time through a single data port. An option register gates the whole path, sets which address register carries the high pointer byte, and can make the pointer step forward after every data access. That lets a block of memory be streamed without reloading the address.

The memory itself sits outside the block, on a synchronous single-port interface with one cycle of read latency. Every host read, whether of a register or of memory, answers one cycle after it is accepted, with `host_rvalid` high. While a read answer is pending, `host_ready` is low and host strobes are not accepted.

A three-state machine sequences the accesses:
- **IDLE**: accepts strobes. Writes complete in this state.
- **RD_REG**: returns a register value.
- **RD_MEM**: returns a memory byte and performs the post-read pointer step.

The transitions are:
- IDLE→RD_MEM on a data-port read while enabled.
- IDLE→RD_REG on any other read.
- RD_REG→IDLE and RD_MEM→IDLE unconditionally.
- IDLE→IDLE on writes or no strobe.

Top module: `idm_bridge`

## Requirements
- R1: After reset, the option register and the pointer are zero, `host_ready` is 1 and `host_rvalid` is 0.
- R2: The option register is at offset 0x0C. Bit 7 enables the memory path, bit 1 selects the address byte order, and bit 0 enables auto-step. Bits 6..2 ignore writes and read as 0.
- R3: With bit 1 at 0, offset 0x0D reads and writes the high pointer byte and offset 0x0E the low byte.
- R4: With bit 1 at 1, offset 0x0D holds the low byte and 0x0E the high byte. Changing bit 1 swaps the readback without altering the pointer.
- R5: An accepted data write (offset 0x0F) while enabled raises `mem_we` in the same cycle, with `mem_addr` equal to the pointer and `mem_wdata` equal to the host byte. `mem_we` and `mem_re` are never high together.
- R6: An accepted data read while enabled returns the memory byte at the pointer in the next cycle, with `host_rvalid` 1 and `host_ready` 0.
- R7: Reads of the option and address registers also answer one cycle after acceptance, with `host_rvalid` 1.
- R8: With auto-step on, each enabled data access adds one to the pointer. After a write, the pointer is updated by the next cycle. After a read, it is updated once the answer cycle ends. 0xFFFF wraps to 0x0000.
- R9: With auto-step off, data accesses leave the pointer unchanged, so a data read right after a data write returns the byte just written.
- R10: With bit 7 at 0, data reads return 0, data writes are dropped, no memory strobe is raised and the pointer does not move.
- R11: Offsets other than 0x0C..0x0F ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ofs | input | OFS_W | Register offset |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read answer present |
| host_ready | output | 1 | Strobe is accepted this cycle |
| mem_addr | output | ADDR_W | Memory address (the pointer) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_rdata | input | DATA_W | Memory read byte, one cycle after mem_re |

## Verification
The hardest situation to reach is the auto-step carry across the pointer's top end. It is harder still when it combines with a byte-order flip, where the same stepped pointer must read back swapped between the two address offsets. Directed sequences load 0xFFFF in one byte order, step it through a data write, and read the wrapped pointer back in both orders. Constrained random traffic then mixes option rewrites, which keep the path mostly enabled, with pointer loads and data accesses. This makes order changes land between auto-stepped accesses.

// File: rtl/idm_pkg.sv
package idm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_REG = 2'd1,
        ST_RD_MEM = 2'd2
    } idm_state_e;

    localparam int OPT_EN_BIT  = 7;
    localparam int OPT_LE_BIT  = 1;
    localparam int OPT_INC_BIT = 0;

    localparam int OFS_OPT  = 'h0C;
    localparam int OFS_ADR0 = 'h0D;
    localparam int OFS_ADR1 = 'h0E;
    localparam int OFS_DATA = 'h0F;

endpackage

// File: rtl/idm_fsm.sv
module idm_fsm
    import idm_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic             host_we,
    input  logic [OFS_W-1:0] host_ofs,
    input  logic             ind_en,
    input  logic             auto_inc,
    output logic             host_ready,
    output logic             host_rvalid,
    output logic             rd_from_mem,
    output logic             mem_re,
    output logic             mem_we,
    output logic             addr_inc,
    output logic             opt_wr,
    output logic             adr0_wr,
    output logic             adr1_wr,
    output logic [OFS_W-1:0] rd_ofs
);

    idm_state_e state_q, state_d;
    logic       hit_opt, hit_adr0, hit_adr1, hit_data;

    assign hit_opt  = (host_ofs == OFS_W'(OFS_OPT));
    assign hit_adr0 = (host_ofs == OFS_W'(OFS_ADR0));
    assign hit_adr1 = (host_ofs == OFS_W'(OFS_ADR1));
    assign hit_data = (host_ofs == OFS_W'(OFS_DATA));

    // state register and captured read offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_ofs  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && host_sel && !host_we)
                rd_ofs <= host_ofs;
        end
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (host_sel && !host_we)
                    state_d = (hit_data && ind_en) ? ST_RD_MEM : ST_RD_REG;
            end
            ST_RD_REG: state_d = ST_IDLE;
            ST_RD_MEM: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_ready  = 1'b0;
        host_rvalid = 1'b0;
        rd_from_mem = 1'b0;
        mem_re      = 1'b0;
        mem_we      = 1'b0;
        addr_inc    = 1'b0;
        opt_wr      = 1'b0;
        adr0_wr     = 1'b0;
        adr1_wr     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                host_ready = 1'b1;
                if (host_sel && host_we) begin
                    opt_wr   = hit_opt;
                    adr0_wr  = hit_adr0;
                    adr1_wr  = hit_adr1;
                    mem_we   = hit_data && ind_en;
                    addr_inc = hit_data && ind_en && auto_inc;
                end else if (host_sel) begin
                    mem_re = hit_data && ind_en;
                end
            end
            ST_RD_REG: begin
                host_rvalid = 1'b1;
            end
            ST_RD_MEM: begin
                host_rvalid = 1'b1;
                rd_from_mem = 1'b1;
                addr_inc    = auto_inc;
            end
            default: begin
                host_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idm_opt_reg.sv
module idm_opt_reg
    import idm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ind_en,
    output logic              little,
    output logic              auto_inc,
    output logic [DATA_W-1:0] rb
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_en   <= 1'b0;
            little   <= 1'b0;
            auto_inc <= 1'b0;
        end else if (wr) begin
            ind_en   <= wdata[OPT_EN_BIT];
            little   <= wdata[OPT_LE_BIT];
            auto_inc <= wdata[OPT_INC_BIT];
        end
    end

    always_comb begin
        rb              = '0;
        rb[OPT_EN_BIT]  = ind_en;
        rb[OPT_LE_BIT]  = little;
        rb[OPT_INC_BIT] = auto_inc;
    end

endmodule

// File: rtl/idm_addr_reg.sv
module idm_addr_reg #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              wr1,
    input  logic [DATA_W-1:0] wdata,
    input  logic              little,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rb0,
    output logic [DATA_W-1:0] rb1
);

    localparam int LANES = ADDR_W / DATA_W;

    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] lane_val [LANES];
    logic              lane0_of_ofs0;

    // lane index held by offset 0x0D: lane 1 (high) when big order
    assign lane0_of_ofs0 = little;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_val[g] = addr[g*DATA_W +: DATA_W];
    end

    always_comb begin
        addr_d = addr;
        if (inc) begin
            addr_d = addr + ADDR_W'(1);
        end else begin
            if (wr0) begin
                if (lane0_of_ofs0) addr_d[0 +: DATA_W]      = wdata;
                else               addr_d[DATA_W +: DATA_W] = wdata;
            end
            if (wr1) begin
                if (lane0_of_ofs0) addr_d[DATA_W +: DATA_W] = wdata;
                else               addr_d[0 +: DATA_W]      = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr <= '0;
        else        addr <= addr_d;
    end

    assign rb0 = little ? lane_val[0] : lane_val[1];
    assign rb1 = little ? lane_val[1] : lane_val[0];

endmodule

// File: rtl/idm_bridge.sv
module idm_bridge
    import idm_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int OFS_W  = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [OFS_W-1:0]  host_ofs,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              host_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              ind_en, little, auto_inc;
    logic              rd_from_mem, addr_inc;
    logic              opt_wr, adr0_wr, adr1_wr;
    logic [OFS_W-1:0]  rd_ofs;
    logic [DATA_W-1:0] opt_rb, adr0_rb, adr1_rb, reg_rb;

    idm_fsm #(.OFS_W(OFS_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_sel    (host_sel),
        .host_we     (host_we),
        .host_ofs    (host_ofs),
        .ind_en      (ind_en),
        .auto_inc    (auto_inc),
        .host_ready  (host_ready),
        .host_rvalid (host_rvalid),
        .rd_from_mem (rd_from_mem),
        .mem_re      (mem_re),
        .mem_we      (mem_we),
        .addr_inc    (addr_inc),
        .opt_wr      (opt_wr),
        .adr0_wr     (adr0_wr),
        .adr1_wr     (adr1_wr),
        .rd_ofs      (rd_ofs)
    );

    idm_opt_reg #(.DATA_W(DATA_W)) u_opt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (opt_wr),
        .wdata    (host_wdata),
        .ind_en   (ind_en),
        .little   (little),
        .auto_inc (auto_inc),
        .rb       (opt_rb)
    );

    idm_addr_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr0    (adr0_wr),
        .wr1    (adr1_wr),
        .wdata  (host_wdata),
        .little (little),
        .inc    (addr_inc),
        .addr   (mem_addr),
        .rb0    (adr0_rb),
        .rb1    (adr1_rb)
    );

    assign mem_wdata = host_wdata;

    always_comb begin
        if (rd_ofs == OFS_W'(OFS_OPT))       reg_rb = opt_rb;
        else if (rd_ofs == OFS_W'(OFS_ADR0)) reg_rb = adr0_rb;
        else if (rd_ofs == OFS_W'(OFS_ADR1)) reg_rb = adr1_rb;
        else                                 reg_rb = '0;
    end

    assign host_rdata = !host_rvalid ? '0 : (rd_from_mem ? mem_rdata : reg_rb);

endmodule

// File: rtl/idm_bridge_chk.sv
module idm_bridge_chk #(
    parameter int OFS_W  = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_we,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ind_en,
    input logic              auto_inc
);

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel && host_ready && !host_we |=> host_rvalid); // R6

    AST_BUSY_WHILE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !host_ready); // R7

    AST_ONE_MEM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we})); // R5

    AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_en |-> !mem_re && !mem_we); // R10

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && auto_inc |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1)); // R8

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re && auto_inc |=> ##1 mem_addr == ADDR_W'($past(mem_addr, 2) + 1'b1)); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !auto_inc |=> $stable(mem_addr)); // R9

endmodule

bind idm_bridge idm_bridge_chk #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_we     (host_we),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_re      (mem_re),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .ind_en      (ind_en),
    .auto_inc    (auto_inc)
);

// File: tb/tb_idm_bridge.sv
module tb_idm_bridge;

    localparam int DW = 8;
    localparam int OW = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel = 1'b0;
    logic          host_we = 1'b0;
    logic [OW-1:0] host_ofs = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rvalid, host_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    logic mon_on = 1'b0;

    // bench-side memory and reference state
    logic [DW-1:0] ram [256];
    logic [DW-1:0] ref_mem [256];
    logic [AW-1:0] ref_ptr = '0;
    logic [DW-1:0] ref_opt = '0;

    always #10 clk = ~clk;

    idm_bridge dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_sel    (host_sel),
        .host_we     (host_we),
        .host_ofs    (host_ofs),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .host_ready  (host_ready),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
        if (mon_on && (mem_we || mem_re)) strobes++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [OW-1:0] ofs);
        logic le;
        le = ref_opt[1];
        case (ofs)
            8'h0C: return ref_opt;
            8'h0D: return le ? ref_ptr[7:0] : ref_ptr[15:8];
            8'h0E: return le ? ref_ptr[15:8] : ref_ptr[7:0];
            8'h0F: return ref_opt[7] ? ref_mem[ref_ptr[7:0]] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [OW-1:0] ofs, input logic [DW-1:0] d);
        logic hi;
        case (ofs)
            8'h0C: ref_opt = d & 8'h83;
            8'h0D, 8'h0E: begin
                hi = (ofs == 8'h0D) ^ ref_opt[1];
                if (hi) ref_ptr[15:8] = d;
                else    ref_ptr[7:0]  = d;
            end
            8'h0F: if (ref_opt[7]) begin
                ref_mem[ref_ptr[7:0]] = d;
                if (ref_opt[0]) ref_ptr = ref_ptr + 16'd1;
            end
            default: ;
        endcase
    endtask

    task automatic hwrite(input logic [OW-1:0] ofs, input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_ofs = ofs; host_wdata = d;
        #1;
        if (ofs == 8'h0F && ref_opt[7]) begin
            chk({tag, " R5 mem_we"}, mem_we, 1);
            chk({tag, " R5 mem_addr"}, mem_addr, ref_ptr);
            chk({tag, " R5 mem_wdata"}, mem_wdata, d);
        end
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
        model_write(ofs, d);
    endtask

    task automatic hread(input logic [OW-1:0] ofs, input string tag);
        logic [DW-1:0] e;
        e = exp_read(ofs);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_ofs = ofs;
        @(negedge clk);
        host_sel = 1'b0;
        chk({tag, " R7 rvalid"}, host_rvalid, 1);
        chk({tag, " R6 busy"}, host_ready, 0);
        chk({tag, " data"}, host_rdata, e);
        if (ofs == 8'h0F && ref_opt[7] && ref_opt[0]) ref_ptr = ref_ptr + 16'd1;
    endtask

    task automatic set_ptr(input logic [AW-1:0] p);
        if (ref_opt[1]) begin
            hwrite(8'h0D, p[7:0], "ptr");
            hwrite(8'h0E, p[15:8], "ptr");
        end else begin
            hwrite(8'h0D, p[15:8], "ptr");
            hwrite(8'h0E, p[7:0], "ptr");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = '0;
            ref_mem[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk("R1 ready", host_ready, 1);
        chk("R1 rvalid", host_rvalid, 0);
        chk("R1 mem_addr", mem_addr, 0);
        hread(8'h0C, "R1 option");

        // R2 reserved bits
        hwrite(8'h0C, 8'hFF, "R2");
        hread(8'h0C, "R2 reserved read 0");
        hwrite(8'h0C, 8'h80, "R2");

        // R3 big order
        set_ptr(16'hA15C);
        hread(8'h0D, "R3 high byte");
        hread(8'h0E, "R3 low byte");
        chk("R3 mem_addr", mem_addr, 16'hA15C);

        // R4 flip order, pointer kept
        hwrite(8'h0C, 8'h82, "R4");
        hread(8'h0D, "R4 low byte");
        hread(8'h0E, "R4 high byte");
        set_ptr(16'h3477);
        chk("R4 mem_addr", mem_addr, 16'h3477);

        // R9 read-after-write, no step
        hwrite(8'h0F, 8'h5A, "R9");
        chk("R9 ptr hold", mem_addr, 16'h3477);
        hread(8'h0F, "R9 raw");
        chk("R9 ptr hold rd", mem_addr, 16'h3477);

        // R8 wrap with auto-step, both orders
        hwrite(8'h0C, 8'h81, "R8");
        set_ptr(16'hFFFF);
        hwrite(8'h0F, 8'hC3, "R8 wrap");
        chk("R8 wrapped", mem_addr, 16'h0000);
        hread(8'h0D, "R8 wrap rb");
        hwrite(8'h0C, 8'h83, "R8");
        set_ptr(16'h10FE);
        hread(8'h0F, "R6/R8 stream a");
        hread(8'h0F, "R6/R8 stream b");
        @(negedge clk);
        chk("R8 step after read", mem_addr, 16'h1100);
        hread(8'h0E, "R8 high rb");

        // R10 disabled path
        hwrite(8'h0C, 8'h03, "R10");
        mon_on = 1'b1;
        hwrite(8'h0F, 8'hEE, "R10");
        hread(8'h0F, "R10 read zero");
        mon_on = 1'b0;
        chk("R10 no strobes", strobes, 0);
        chk("R10 ptr hold", mem_addr, ref_ptr);
        hwrite(8'h0C, 8'h80, "R10");
        hread(8'h0F, "R10 write dropped");

        // R11 unmapped
        hwrite(8'h0B, 8'hFF, "R11");
        hwrite(8'h10, 8'hFF, "R11");
        hread(8'h0B, "R11 read zero");
        hread(8'h0C, "R11 option intact");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [DW-1:0] d;
            op = int'($urandom % 8);
            d = 8'($urandom);
            case (op)
                0: hwrite(8'h0C, {($urandom % 4 != 0), d[6:0]}, "rnd opt");
                1: hwrite(8'h0D, d, "rnd adr0");
                2: hwrite(8'h0E, d, "rnd adr1");
                3, 4: hwrite(8'h0F, d, "rnd R5 data");
                5: hread(8'h0F, "rnd R6 data");
                6: hread(8'($urandom % 3 + 12), "rnd R7 reg");
                default: hread(8'h20 + d[3:0], "rnd R11");
            endcase
        end
        @(negedge clk);
        chk("rnd R8 final ptr", mem_addr, ref_ptr);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule